// File: doc/BRIEF.md
# PCI Slot Hotplug Controller

This block keeps the slot bookkeeping that firmware uses to hot add and hot remove cards on a PCI segment with up to 32 slots. It holds three masks: which slots hold a card, which slots may be removed (hotplug allowed), and which slots have a removal request that software has not yet serviced. Insertion and removal notices arrive on a small valid/ready event channel. Each hot event sends a one-cycle pulse to the general-purpose event aggregator, which sets status bit 1 (value 0x2) in its own register file. Software sees four 32-bit registers in an I/O window and acknowledges a removal by writing an eject mask. The block then reports each slot it actually frees on a strobe output.

The event channel follows the usual valid/ready rule. A notice is taken on the clock edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high the producer holds kind and slot stable. `ev_ready` is low during reset and during the warm-reset sequence, so notices wait at the producer and are never dropped. A warm reset first services every pending removal, lowest slot first, one per cycle. It then reloads presence and removability from the platform's discovery vectors.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Registers sit in a 16-byte window at parameter `BASE` (default 0xAE00), selected by address bits [3:2]: 0x0 inserted view, 0x4 pending-removal mask, 0x8 eject (write) and feature word (read), 0xC removable mask. A read inside the window answers with `rsp_valid` high for one cycle, one clock after the request.
- R2: The inserted view is computed live as presence AND removable. No separate latch is kept, so a slot holding a card may be reported again.
- R3: A read of the feature word (offset 0x8) returns zero.
- R4: An accepted hot-add notice (kind 2'b01) for slot n sets presence bit n. It also pulses `gpe_pulse` for one cycle, one clock after acceptance.
- R5: An accepted removal notice (kind 2'b10) for slot n sets pending bit n and pulses `gpe_pulse`. Presence stays unchanged.
- R6: A cold-add notice (kind 2'b00) sets presence bit n without any pulse. Kind 2'b11 changes nothing and gives no pulse.
- R7: An eject write acts on the lowest set bit only. It clears that slot's pending bit. If the slot is removable, it also clears presence and pulses `freed_valid` with `freed_slot` = n one clock later. A write of zero changes nothing.
- R8: An eject of a non-removable slot clears its pending bit only. Presence is kept and no `freed_valid` pulse is given.
- R9: During reset (`rst` high, synchronous), presence loads `boot_present`, removable loads the inverse of `boot_fixed`, and pending clears. These values hold after reset is released.
- R10: A `warm_rst` pulse drops `ev_ready` and then services pending removals one per cycle, lowest slot first, each exactly as in R7. In the cycle that finds the pending mask empty, presence and removable reload as in R9 and `ev_ready` returns high. Register writes are ignored during the sequence.
- R11: Only 32-bit accesses (`reg_size` = 2'b10) act. A narrower read answers zero and a narrower write is ignored. Addresses outside the window get no response.
- R12: An eject write and an accepted notice in the same cycle both take effect. For the same slot, the notice's set takes priority over the eject's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warm_rst | input | 1 | Warm reset request pulse (drain, then re-discover) |
| boot_present | input | 32 | Slots found holding a card at discovery |
| boot_fixed | input | 32 | Slots holding non-removable cards at discovery |
| reg_addr | input | 16 | I/O byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| ev_valid | input | 1 | Event notice valid |
| ev_ready | output | 1 | Event notice accepted when high with valid |
| ev_kind | input | 2 | 00 cold add, 01 hot add, 10 removal request, 11 none |
| ev_slot | input | 5 | Slot number of the notice |
| gpe_pulse | output | 1 | One-cycle pulse setting event status bit 1 |
| freed_valid | output | 1 | One-cycle strobe: a slot was freed |
| freed_slot | output | 5 | Slot freed, valid with freed_valid |

## Verification
The eject path and the notice path both write the pending and presence masks, so the bench drives a removal notice and an eject write for the same slot in one cycle. The result is judged at the ports. The pending mask must still show the slot, because the new request outlives the acknowledgement. The freed strobe must name that slot, and the event pulse count must rise by one. A warm reset with two slots pending also lines up drain ejects and the reload back to back, and the scoreboard checks the order of the freed slots.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    EV_COLD = 2'b00,
    EV_ADD  = 2'b01,
    EV_DEL  = 2'b10,
    EV_NONE = 2'b11
  } ev_kind_e;

  typedef enum logic {
    SEQ_RUN   = 1'b0,
    SEQ_DRAIN = 1'b1
  } seq_e;

  typedef enum logic [1:0] {
    SEL_INS  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EJ   = 2'd2,
    SEL_RMV  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
  import hp_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hAE00
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    size,
  output logic          rd_hit,
  output logic          rd_word,
  output reg_sel_e      sel,
  output logic          ej_wr
);
  localparam int WIN_LSB = 4;

  logic in_win;
  logic is_word;

  always_comb begin
    in_win  = (addr[AW-1:WIN_LSB] == BASE[AW-1:WIN_LSB]);
    is_word = (size == SIZE_WORD) && (addr[1:0] == 2'b00);
    sel     = reg_sel_e'(addr[3:2]);
    rd_hit  = rd && in_win;
    rd_word = rd_hit && is_word;
    ej_wr   = wr && in_win && is_word && (sel == SEL_EJ);
  end
endmodule

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int N = 32,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [SW-1:0] idx,
  output logic [N-1:0]  oh
);
  always_comb begin
    any = |vec;
    oh  = vec & (~vec + {{(N-1){1'b0}}, 1'b1});
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = SW'(i);
    end
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_pkg::*;
#(
  parameter int N = 32,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_rst,
  input  logic [N-1:0]  boot_present,
  input  logic [N-1:0]  boot_fixed,
  input  logic          ev_valid,
  input  ev_kind_e      ev_kind,
  input  logic [SW-1:0] ev_slot,
  output logic          ev_ready,
  input  logic          ej_wr,
  input  logic [N-1:0]  ej_data,
  output logic [N-1:0]  present_q,
  output logic [N-1:0]  rmv_q,
  output logic [N-1:0]  pend_q,
  output logic          gpe_pulse,
  output logic          freed_valid,
  output logic [SW-1:0] freed_slot
);
  seq_e          st_q;
  logic          ev_acc;
  logic [N-1:0]  ev_oh;
  logic [N-1:0]  set_pres, set_pend;
  logic          hot_evt;
  logic [N-1:0]  ej_src;
  logic          ej_go;
  logic [SW-1:0] ej_idx;
  logic [N-1:0]  ej_oh;
  logic          ej_free;
  logic [N-1:0]  clr_pres, clr_pend;

  always_comb begin
    ev_ready = (st_q == SEQ_RUN) && !rst;
    ev_acc   = ev_valid && ev_ready;
    ev_oh    = {{(N-1){1'b0}}, 1'b1} << ev_slot;
    set_pres = (ev_acc && (ev_kind == EV_COLD || ev_kind == EV_ADD)) ? ev_oh : '0;
    set_pend = (ev_acc && ev_kind == EV_DEL) ? ev_oh : '0;
    hot_evt  = ev_acc && (ev_kind == EV_ADD || ev_kind == EV_DEL);
    if (st_q == SEQ_DRAIN)  ej_src = pend_q;
    else if (ej_wr)         ej_src = ej_data;
    else                    ej_src = '0;
  end

  hp_lowbit #(.N(N)) u_low (
    .vec (ej_src),
    .any (ej_go),
    .idx (ej_idx),
    .oh  (ej_oh)
  );

  always_comb begin
    ej_free  = ej_go && rmv_q[ej_idx];
    clr_pend = ej_go ? ej_oh : '0;
    clr_pres = ej_free ? ej_oh : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q   <= boot_present;
      rmv_q       <= ~boot_fixed;
      pend_q      <= '0;
      st_q        <= SEQ_RUN;
      gpe_pulse   <= 1'b0;
      freed_valid <= 1'b0;
      freed_slot  <= '0;
    end else begin
      gpe_pulse   <= hot_evt;
      freed_valid <= ej_free;
      if (ej_free) freed_slot <= ej_idx;
      if (st_q == SEQ_DRAIN && pend_q == '0) begin
        present_q <= boot_present;
        rmv_q     <= ~boot_fixed;
        st_q      <= SEQ_RUN;
      end else begin
        present_q <= (present_q & ~clr_pres) | set_pres;
        pend_q    <= (pend_q & ~clr_pend) | set_pend;
        if (st_q == SEQ_RUN && warm_rst) st_q <= SEQ_DRAIN;
      end
    end
  end

  // R4
  hot_gpe_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready && (ev_kind == EV_ADD || ev_kind == EV_DEL) |=> gpe_pulse);

  // R6
  cold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready && (ev_kind == EV_COLD || ev_kind == EV_NONE) |=> !gpe_pulse);

  // R7
  zero_eject_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == SEQ_RUN && ej_wr && ej_data == '0 && !(ev_valid && ev_ready)
    |=> $stable(pend_q) && $stable(present_q) && !freed_valid);

  // R8
  fixed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ej_go && !rmv_q[ej_idx] && !(ev_valid && ev_ready)
    |=> ((present_q ^ $past(present_q)) & $past(ej_oh)) == '0 && !freed_valid);

  // R10
  drain_step_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == SEQ_DRAIN && pend_q != '0
    |=> $countones(pend_q) == $countones($past(pend_q)) - 1);

  // R10
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(warm_rst) && $past(ev_ready) |-> !ev_ready);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int N = 32,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 16'hAE00,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          warm_rst,
  input  logic [N-1:0]  boot_present,
  input  logic [N-1:0]  boot_fixed,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_size,
  input  logic [DW-1:0] reg_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [1:0]    ev_kind,
  input  logic [SW-1:0] ev_slot,
  output logic          gpe_pulse,
  output logic          freed_valid,
  output logic [SW-1:0] freed_slot
);
  logic         rd_hit, rd_word, ej_wr;
  reg_sel_e     sel;
  logic [N-1:0] present_q, rmv_q, pend_q;
  logic [DW-1:0] rd_mux;

  hp_reg_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .size    (reg_size),
    .rd_hit  (rd_hit),
    .rd_word (rd_word),
    .sel     (sel),
    .ej_wr   (ej_wr)
  );

  hp_slot_state #(.N(N)) u_state (
    .clk          (clk),
    .rst          (rst),
    .warm_rst     (warm_rst),
    .boot_present (boot_present),
    .boot_fixed   (boot_fixed),
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind_e'(ev_kind)),
    .ev_slot      (ev_slot),
    .ev_ready     (ev_ready),
    .ej_wr        (ej_wr),
    .ej_data      (reg_wdata[N-1:0]),
    .present_q    (present_q),
    .rmv_q        (rmv_q),
    .pend_q       (pend_q),
    .gpe_pulse    (gpe_pulse),
    .freed_valid  (freed_valid),
    .freed_slot   (freed_slot)
  );

  always_comb begin
    unique case (sel)
      SEL_INS:  rd_mux = DW'(present_q & rmv_q);
      SEL_PEND: rd_mux = DW'(pend_q);
      SEL_EJ:   rd_mux = '0;
      SEL_RMV:  rd_mux = DW'(rmv_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_hit;
      rsp_data  <= rd_word ? rd_mux : '0;
    end
  end

  // R3
  feature_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_word) && $past(sel == SEL_EJ) |-> rsp_valid && rsp_data == '0);

  // R11
  narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit) && !$past(rd_word) |-> rsp_valid && rsp_data == '0);

  // R1
  rsp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_hit) |-> !rsp_valid);
endmodule

// File: tb/sim_hp_slot_ctrl.sv
module sim_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic [31:0] boot_present = 32'h0000_0013;
  logic [31:0] boot_fixed = 32'h0000_0001;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_size = 2'b10;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [1:0]  ev_kind = '0;
  logic [4:0]  ev_slot = '0;
  logic        gpe_pulse;
  logic        freed_valid;
  logic [4:0]  freed_slot;

  int n_tests = 0;
  int n_fail = 0;
  int gpe_cnt = 0;
  bit done = 0;
  int exp_q[$];

  localparam logic [15:0] BASE = 16'hAE00;

  always #5 clk = ~clk;

  hp_slot_ctrl u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .boot_present(boot_present), .boot_fixed(boot_fixed),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_size(reg_size), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
    .ev_slot(ev_slot), .gpe_pulse(gpe_pulse),
    .freed_valid(freed_valid), .freed_slot(freed_slot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: freed strobes against expected queue
  always @(negedge clk) begin
    if (!rst && freed_valid) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected freed", 32'(freed_slot), 32'hFFFF_FFFF);
      end else begin
        chk("R7 freed slot", 32'(freed_slot), 32'(exp_q.pop_front()));
      end
    end
    if (!rst && gpe_pulse) gpe_cnt++;
  end

  task automatic rd(input logic [15:0] addr, input logic [1:0] sz,
                    input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = addr; reg_size = sz; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0; reg_size = 2'b10;
    @(negedge clk);
    chk(tag, rsp_valid ? rsp_data : 32'hDEAD_BEEF, exp);
  endtask

  task automatic wr(input logic [15:0] addr, input logic [1:0] sz, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = addr; reg_size = sz; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_size = 2'b10;
  endtask

  task automatic ev(input logic [1:0] k, input logic [4:0] s);
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_kind = k; ev_slot = s;
    do @(negedge clk); while (!ev_ready);
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  task automatic ev_and_eject(input logic [1:0] k, input logic [4:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    ev_valid = 1'b1; ev_kind = k; ev_slot = s;
    reg_addr = BASE | 16'h8; reg_size = 2'b10; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    ev_valid = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ev_ready", 32'(ev_ready), 32'd1);
    rd(BASE | 16'h0, 2'b10, 32'h0000_0012, "R9 R2 inserted");
    rd(BASE | 16'hC, 2'b10, 32'hFFFF_FFFE, "R9 removable");
    rd(BASE | 16'h4, 2'b10, 32'h0, "R9 pending");
    rd(BASE | 16'h8, 2'b10, 32'h0, "R3 feature");
    // R6 cold add
    ev(2'b00, 5'd7);
    rd(BASE | 16'h0, 2'b10, 32'h0000_0092, "R6 cold presence");
    chk("R6 no gpe", 32'(gpe_cnt), 32'd0);
    // R4 hot add
    ev(2'b01, 5'd9);
    rd(BASE | 16'h0, 2'b10, 32'h0000_0292, "R4 hot presence");
    chk("R4 gpe", 32'(gpe_cnt), 32'd1);
    // R6 kind 11
    ev(2'b11, 5'd12);
    rd(BASE | 16'h0, 2'b10, 32'h0000_0292, "R6 none kind");
    chk("R6 none gpe", 32'(gpe_cnt), 32'd1);
    // R5 removal requests
    ev(2'b10, 5'd4);
    ev(2'b10, 5'd9);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0210, "R5 pending");
    rd(BASE | 16'h0, 2'b10, 32'h0000_0292, "R5 presence kept");
    chk("R5 gpe", 32'(gpe_cnt), 32'd3);
    // R7 eject lowest bit
    exp_q.push_back(4);
    wr(BASE | 16'h8, 2'b10, 32'h0000_0210);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0200, "R7 pending after eject");
    rd(BASE | 16'h0, 2'b10, 32'h0000_0282, "R7 presence after eject");
    // R7 zero write
    wr(BASE | 16'h8, 2'b10, 32'h0);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0200, "R7 zero eject");
    // R8 non-removable slot 0
    ev(2'b10, 5'd0);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0201, "R8 pending fixed");
    wr(BASE | 16'h8, 2'b10, 32'h0000_0001);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0200, "R8 pending cleared");
    chk("R8 no freed", 32'(exp_q.size()), 32'd0);
    chk("R8 gpe", 32'(gpe_cnt), 32'd4);
    // R11 narrow and out-of-window
    wr(BASE | 16'h8, 2'b01, 32'h0000_0200);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0200, "R11 narrow write");
    rd(BASE | 16'h0, 2'b00, 32'h0, "R11 narrow read");
    rd(16'hAF00, 2'b10, 32'hDEAD_BEEF, "R11 outside window");
    // R12 removal notice and eject of same slot together
    exp_q.push_back(9);
    ev_and_eject(2'b10, 5'd9, 32'h0000_0200);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0200, "R12 pending survives");
    rd(BASE | 16'h0, 2'b10, 32'h0000_0082, "R12 presence cleared");
    chk("R12 gpe", 32'(gpe_cnt), 32'd5);
    // R10 warm reset drain and reload
    ev(2'b10, 5'd7);
    rd(BASE | 16'h4, 2'b10, 32'h0000_0280, "R10 pending before");
    boot_present = 32'h0000_0103;
    boot_fixed = 32'h0000_0002;
    exp_q.push_back(7);
    exp_q.push_back(9);
    @(posedge clk); #1 warm_rst = 1'b1;
    @(posedge clk); #1 warm_rst = 1'b0;
    @(negedge clk);
    chk("R10 ready low", 32'(ev_ready), 32'd0);
    while (!ev_ready) @(negedge clk);
    rd(BASE | 16'h0, 2'b10, 32'h0000_0101, "R10 inserted reload");
    rd(BASE | 16'hC, 2'b10, 32'hFFFF_FFFD, "R10 removable reload");
    rd(BASE | 16'h4, 2'b10, 32'h0, "R10 pending empty");
    chk("R10 R7 all freed seen", 32'(exp_q.size()), 32'd0);
    chk("R10 gpe", 32'(gpe_cnt), 32'd6);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule